// File: doc/BRIEF.md
# Dual-Tone Direct Digital Synthesis Channel Generator

The block produces one signed 16-bit sample per clock for each of `NUM_CH` output channels. Every channel adds two independent synthesized tones. A tone is a 16-bit phase accumulator that steps by a programmable frequency word each clock. A programmable phase offset is added to the accumulator, and the top eight bits of that sum select a point on a 256-entry waveform table. The waveform value is then scaled by a signed gain. The two scaled tones are added and clamped to the 16-bit output range.

Software programs tone settings through a simple register write port. Those writes land in shadow registers and do not reach the datapath straight away. A write to a global control word with its strobe bit set loads every channel's shadow settings into the active registers in the same cycle and restarts all accumulators from zero. Multi-channel outputs therefore start phase-aligned. When the synthesizer is configured as absent (parameter `HAS_DDS` = 0), the block drives silence and tone registers have no effect.

Top module: `dtdds_gen`

## Requirements
- R1: Each tone's 16-bit accumulator starts at zero when settings are applied. It then grows by that tone's frequency word once per clock and wraps modulo 2^16.
- R2: The waveform index is bits 15:8 of (accumulator + phase offset) mod 2^16. In a frequency/phase register word, the frequency is bits 15:0 and the phase offset is bits 31:16.
- R3: The waveform value for index k is built as follows: x = k mod 128, and m = min(8·x·(128−x), 32767). The value is +m for k < 128 and −m for k ≥ 128.
- R4: A gain word uses bit 15 as the sign and bits 14:0 as the magnitude, where 0x4000 means 1.0. The scaled tone is floor(wave·magnitude / 2^14), and it is negated when the sign bit is 1.
- R5: Channel c occupies byte addresses c·0x40 + offset. Offset 0x00 is the first tone's gain and 0x04 is its frequency/phase word. Offset 0x08 is the second tone's gain and 0x0C is its frequency/phase word. Gain registers keep only bits 15:0. Writes with address bits 1:0 not zero, writes to other offsets and writes to channels at or above `NUM_CH` are ignored.
- R6: Register writes do not change the output until a write to `CTRL_ADDR` (default 0x800) with bit 0 set. The internal strobe lasts one clock. On the next edge, all channels load their shadow settings together and clear their accumulators. The sample that appears two clocks after the strobe write edge is computed with accumulator value 0.
- R7: The sum of the two scaled tones saturates to the range −32768 to 32767 instead of wrapping.
- R8: With `HAS_DDS` = 0, every output sample is zero whatever is written.
- R9: Synchronous active-high reset clears the shadow and active settings, the accumulators and the outputs, so the samples read zero after reset.
- R10: A write to `CTRL_ADDR` with bit 0 clear does not apply the pending settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Register write data |
| samples_o | output | 16·NUM_CH | Signed sample per channel, channel c in bits 16c+15:16c |

## Verification
A slow single tone at unity gain sweeps all 256 waveform indices, which separates errors in the table shape, the index bit selection and the accumulator step. A second tone with a negative gain and a half-turn phase offset checks the sign handling and the offset addition independently of frequency. Equal full-gain tones parked at the waveform peak, one pair positive and one pair negative, drive both saturation limits. Randomized settings on all channels, each followed by a strobe, compare every sample against a cycle-level model. Writes made before the strobe, strobe-less control writes and out-of-range addresses show whether shadowing and address decode hold the active settings unchanged.

// File: rtl/dtdds_pkg.sv
package dtdds_pkg;

    localparam int ACC_W     = 16;
    localparam int IDX_W     = 8;
    localparam int SAMPLE_W  = 16;
    localparam int GAIN_W    = 16;
    localparam int FRAC_W    = 14;
    localparam int SCALED_W  = 18;
    localparam int SUM_W     = 19;
    localparam int TONES     = 2;
    localparam int STRIDE_LG = 6;   // 0x40 bytes per channel
    localparam int WAVE_LEN  = 1 << IDX_W;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [ACC_W-1:0]  phase;
        logic [ACC_W-1:0]  freq;
    } tone_cfg_t;

    typedef tone_cfg_t [TONES-1:0] chan_cfg_t;

    typedef enum logic [1:0] {
        SEL_GAIN_A = 2'd0,
        SEL_FP_A   = 2'd1,
        SEL_GAIN_B = 2'd2,
        SEL_FP_B   = 2'd3
    } reg_sel_e;

    // Parabolic half-wave approximation of one sine period.
    function automatic logic signed [SAMPLE_W-1:0] wave_point(input int k);
        int x;
        int m;
        x = k % (WAVE_LEN / 2);
        m = 8 * x * ((WAVE_LEN / 2) - x);
        if (m > 32767) m = 32767;
        return (k >= WAVE_LEN / 2) ? SAMPLE_W'(-m) : SAMPLE_W'(m);
    endfunction

    function automatic logic [WAVE_LEN*SAMPLE_W-1:0] build_wave();
        logic [WAVE_LEN*SAMPLE_W-1:0] rom;
        rom = '0;
        for (int k = 0; k < WAVE_LEN; k++) begin
            rom[k*SAMPLE_W +: SAMPLE_W] = wave_point(k);
        end
        return rom;
    endfunction

    function automatic logic signed [SCALED_W-1:0] apply_gain(
        input logic signed [SAMPLE_W-1:0] s,
        input logic [GAIN_W-1:0]          g
    );
        logic signed [31:0] prod;
        logic signed [31:0] shifted;
        prod    = 32'(s) * $signed({17'b0, g[GAIN_W-2:0]});
        shifted = prod >>> FRAC_W;
        return g[GAIN_W-1] ? SCALED_W'(-shifted) : SCALED_W'(shifted);
    endfunction

    localparam logic signed [SUM_W-1:0] SUM_MAX = 32767;
    localparam logic signed [SUM_W-1:0] SUM_MIN = -32768;

    function automatic logic signed [SAMPLE_W-1:0] clamp_sample(
        input logic signed [SUM_W-1:0] v
    );
        if (v > SUM_MAX) return 16'sh7FFF;
        if (v < SUM_MIN) return 16'sh8000;
        return v[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/dtdds_regs.sv
module dtdds_regs
    import dtdds_pkg::*;
#(
    parameter int                NUM_CH    = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h800
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    output chan_cfg_t [NUM_CH-1:0]   shadow_o,
    output logic                     sync_o
);

    localparam int CH_IDX_W = ADDR_W - STRIDE_LG;

    logic [CH_IDX_W-1:0]  ch_idx;
    logic [3:0]           slot;
    logic                 cfg_wr;
    reg_sel_e             sel;
    chan_cfg_t [NUM_CH-1:0] shadow_q;
    logic                 sync_q;
    logic                 ctrl_hit;

    assign ch_idx   = wr_addr[ADDR_W-1:STRIDE_LG];
    assign slot     = wr_addr[STRIDE_LG-1:2];
    assign sel      = reg_sel_e'(slot[1:0]);
    assign cfg_wr   = wr_en && (slot[3:2] == 2'b00) && (wr_addr[1:0] == 2'b00)
                      && (int'(ch_idx) < NUM_CH);
    assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (cfg_wr) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (int'(ch_idx) == c) begin
                    case (sel)
                        SEL_GAIN_A: shadow_q[c][0].gain <= wr_data[15:0];
                        SEL_FP_A:   {shadow_q[c][0].phase, shadow_q[c][0].freq} <= wr_data;
                        SEL_GAIN_B: shadow_q[c][1].gain <= wr_data[15:0];
                        default:    {shadow_q[c][1].phase, shadow_q[c][1].freq} <= wr_data;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= ctrl_hit && wr_data[0];
    end

    assign shadow_o = shadow_q;
    assign sync_o   = sync_q;

    AST_SYNC_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sync_q && !ctrl_hit) |=> !sync_q); // R6

    AST_FOREIGN_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(ch_idx) >= NUM_CH) |=> $stable(shadow_q)); // R5

    AST_CTRL_ZERO_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && !wr_data[0]) |=> !sync_q); // R10

endmodule

// File: rtl/dtdds_tone.sv
module dtdds_tone
    import dtdds_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  tone_cfg_t                   cfg,
    output logic signed [SCALED_W-1:0]  scaled_o
);

    localparam logic [WAVE_LEN*SAMPLE_W-1:0] WAVE = build_wave();

    logic [ACC_W-1:0]           acc_q;
    logic [IDX_W-1:0]           idx;
    logic signed [SAMPLE_W-1:0] wave;

    always_ff @(posedge clk) begin
        if (rst || load) acc_q <= '0;
        else             acc_q <= acc_q + cfg.freq;
    end

    assign idx      = IDX_W'((acc_q + cfg.phase) >> (ACC_W - IDX_W));
    assign wave     = WAVE[int'(idx)*SAMPLE_W +: SAMPLE_W];
    assign scaled_o = apply_gain(wave, cfg.gain);

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc_q == '0)); // R6

endmodule

// File: rtl/dtdds_channel.sv
module dtdds_channel
    import dtdds_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  chan_cfg_t                   shadow_i,
    output logic signed [SAMPLE_W-1:0]  sample_o
);

    chan_cfg_t                   act_q;
    logic signed [SCALED_W-1:0]  scaled [TONES];
    logic signed [SUM_W-1:0]     sum;
    logic signed [SAMPLE_W-1:0]  sample_q;

    always_ff @(posedge clk) begin
        if (rst)       act_q <= '0;
        else if (load) act_q <= shadow_i;
    end

    for (genvar t = 0; t < TONES; t++) begin : g_tone
        dtdds_tone u_tone (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .cfg      (act_q[t]),
            .scaled_o (scaled[t])
        );
    end

    assign sum = SUM_W'(scaled[0]) + SUM_W'(scaled[1]);

    always_ff @(posedge clk) begin
        if (rst) sample_q <= '0;
        else     sample_q <= clamp_sample(sum);
    end

    assign sample_o = sample_q;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act_q)); // R6

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sum > SUM_MAX) |=> (sample_q == 16'sh7FFF)); // R7

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (sum < SUM_MIN) |=> (sample_q == 16'sh8000)); // R7

endmodule

// File: rtl/dtdds_gen.sv
module dtdds_gen
    import dtdds_pkg::*;
#(
    parameter int                NUM_CH    = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h800,
    parameter bit                HAS_DDS   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [31:0]                  wr_data,
    output logic [NUM_CH*SAMPLE_W-1:0]   samples_o
);

    if (HAS_DDS) begin : g_dds
        chan_cfg_t [NUM_CH-1:0] shadow;
        logic                   sync;

        dtdds_regs #(
            .NUM_CH    (NUM_CH),
            .ADDR_W    (ADDR_W),
            .CTRL_ADDR (CTRL_ADDR)
        ) u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .shadow_o (shadow),
            .sync_o   (sync)
        );

        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dtdds_channel u_ch (
                .clk      (clk),
                .rst      (rst),
                .load     (sync),
                .shadow_i (shadow[c]),
                .sample_o (samples_o[c*SAMPLE_W +: SAMPLE_W])
            );
        end
    end else begin : g_absent
        assign samples_o = '0;
    end

    AST_ABSENT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!HAS_DDS) |-> (samples_o == '0)); // R8

endmodule

// File: tb/dtdds_gen_test.sv
`timescale 1ns/1ps
module dtdds_gen_test;

    localparam int NCH  = 4;
    localparam int CTRL = 32'h800;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [11:0]       wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [NCH*16-1:0] samples;
    logic [15:0]       quiet;

    dtdds_gen #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .samples_o(samples)
    );

    dtdds_gen #(.NUM_CH(1), .HAS_DDS(1'b0)) uut_quiet (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .samples_o(quiet)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [31:0] sh_m  [NCH][4];
    logic [31:0] act_m [NCH][4];
    logic [15:0] acc_m [NCH][2];
    bit          pend_m = 1'b0;

    function automatic int wave_ref(int k);
        int x = k % 128;
        int m = 8 * x * (128 - x);
        if (m > 32767) m = 32767;
        return (k >= 128) ? -m : m;
    endfunction

    function automatic int gain_ref(int s, logic [15:0] g);
        int p = s * int'(g[14:0]);
        p = p >>> 14;
        return g[15] ? -p : p;
    endfunction

    function automatic int sample_ref(int ch);
        int sum = 0;
        for (int t = 0; t < 2; t++) begin
            logic [31:0] fp = act_m[ch][2*t+1];
            int pos = (int'(acc_m[ch][t]) + int'(fp[31:16])) % 65536;
            sum += gain_ref(wave_ref(pos / 256), act_m[ch][2*t][15:0]);
        end
        if (sum > 32767)  sum = 32767;
        if (sum < -32768) sum = -32768;
        return sum;
    endfunction

    task automatic check(string tag, int ch, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s ch%0d got %0d expected %0d", tag, ch, got, exp);
        end
    endtask

    task automatic tick(bit we, int addr, logic [31:0] data, string tag);
        int exp [NCH];
        bit r;
        wr_en = we; wr_addr = 12'(addr); wr_data = data;
        @(posedge clk);
        r = rst;
        for (int ch = 0; ch < NCH; ch++) exp[ch] = r ? 0 : sample_ref(ch);
        if (r) begin
            for (int ch = 0; ch < NCH; ch++) begin
                for (int k = 0; k < 4; k++) begin sh_m[ch][k] = '0; act_m[ch][k] = '0; end
                acc_m[ch][0] = '0; acc_m[ch][1] = '0;
            end
            pend_m = 1'b0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                for (int t = 0; t < 2; t++) begin
                    if (pend_m) acc_m[ch][t] = '0;
                    else        acc_m[ch][t] = acc_m[ch][t] + act_m[ch][2*t+1][15:0];
                end
                if (pend_m) for (int k = 0; k < 4; k++) act_m[ch][k] = sh_m[ch][k];
            end
            pend_m = we && (addr == CTRL) && data[0];
            if (we && addr < NCH*64 && (addr % 4) == 0 && (addr % 64) < 16)
                sh_m[addr/64][(addr%64)/4] = data;
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int ch = 0; ch < NCH; ch++)
            check(tag, ch, int'($signed(samples[ch*16 +: 16])), exp[ch]);
        check("R8 absent synthesizer silent", 0, int'($signed(quiet)), 0);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 0, 32'h0, tag);
    endtask

    task automatic set_tone(int ch, int t, logic [15:0] g, logic [15:0] f,
                            logic [15:0] ph, string tag);
        tick(1'b1, ch*64 + t*8, {16'h0, g}, tag);
        tick(1'b1, ch*64 + t*8 + 4, {ph, f}, tag);
    endtask

    task automatic apply(string tag);
        tick(1'b1, CTRL, 32'h1, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        idle(3, "R9 during reset");
        rst = 1'b0;
        idle(4, "R9 after reset");

        set_tone(0, 0, 16'h4000, 16'h0100, 16'h0000, "R6 shadow write");
        apply("R6 strobe");
        idle(300, "R1 R2 R3 R4 single tone sweep");

        set_tone(0, 1, 16'hC000, 16'h0333, 16'h8000, "R6 pending");
        idle(10, "R6 pending not applied");
        tick(1'b1, CTRL, 32'h0, "R10 strobe bit clear");
        idle(10, "R10 settings unchanged");
        apply("R6 strobe");
        idle(200, "R1 R2 R4 two tones");

        tick(1'b1, 12'h010, 32'h0000_7FFF, "R5 bad offset");
        tick(1'b1, 12'h100, 32'h0000_7FFF, "R5 channel out of range");
        tick(1'b1, 12'h002, 32'h0000_7FFF, "R5 misaligned");
        apply("R5 strobe");
        idle(20, "R5 ignored writes");

        for (int t = 0; t < 2; t++) begin
            set_tone(2, t, 16'h7FFF, 16'h0000, 16'h4000, "R7 setup");
            set_tone(3, t, 16'hFFFF, 16'h0000, 16'h4000, "R7 setup");
        end
        apply("R7 strobe");
        idle(6, "R7 saturation");
        check("R7 positive clamp", 2, int'($signed(samples[2*16 +: 16])), 32767);
        check("R7 negative clamp", 3, int'($signed(samples[3*16 +: 16])), -32768);

        for (int r = 0; r < 24; r++) begin
            for (int ch = 0; ch < NCH; ch++)
                for (int t = 0; t < 2; t++)
                    set_tone(ch, t, 16'($urandom), 16'($urandom), 16'($urandom),
                             "R1 R2 R3 R4 random setup");
            apply("R6 random strobe");
            idle(48, "R1 R2 R3 R4 R7 random");
        end

        rst = 1'b1;
        idle(2, "R9 reset mid-run");
        rst = 1'b0;
        idle(3, "R9 after second reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule